// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects interrupt requests from eight input lines and presents the most urgent one to a processor as an interrupt signal and a vector number. Software talks to it through two adjacent byte addresses. Address 0 is the command address and address 1 is the data address. After reset, software programs the block with a short command sequence. The sequence sets the vector base, the lines that lead to secondary controllers, and the end-of-interrupt mode. After that, data-address writes program the per-line mask.

Requests are edge sensitive. A rising edge on a line sets that line's pending bit. Among the unmasked pending lines, the lowest-numbered line wins. The interrupt output is raised only if no line of equal or higher priority is already being serviced. When the processor acknowledges, the winner moves from pending to in-service and its vector is presented. A command write then ends service of the highest in-service line. Software can also pick an automatic mode in which acknowledged lines are never marked in service.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are low. Reads return 0 at both addresses, and `casc_lines` is 0. No line raises the interrupt until a full command sequence has completed.
- R2: A command-address write with bit 4 set starts a new sequence. It clears the mask, all pending bits, all in-service bits, the cascade map and the automatic mode. Its bit 1 set means there is no cascade word. Its bit 0 set means a mode word will follow.
- R3: The first data write after the start word is the vector base, with bits 2:0 ignored. Line n produces vector base + n; for example, base 0x20 gives 0x20 to 0x27.
- R4: The cascade word is expected only when start-word bit 1 is 0. It then appears on `casc_lines`, so 0x04 marks line 2. When bit 1 is 1, the sequence skips this word and `casc_lines` stays 0.
- R5: The mode word is expected only when start-word bit 0 is 1. Its bit 1 selects automatic end of service. Without the mode word, normal end of service applies.
- R6: Once the sequence is complete, each data write loads the mask. Bit n set masks line n, 0xFF masks all lines and 0x00 unmasks all. A read at address 1 returns the mask, and a read at address 0 returns the pending bits.
- R7: A rising edge on a line sets its pending bit. A line held high does not set its pending bit again.
- R8: `int_out` is high when the sequence is complete and at least one unmasked line is pending. The winner is the lowest-numbered such line. Masked pending lines never raise `int_out`.
- R9: An acknowledge while `int_out` is high has three effects. It clears the winner's pending bit and sets its in-service bit. In the next cycle it drives `vec_out` to the winner's vector with `vec_valid` high for one cycle. An acknowledge while `int_out` is low has no effect.
- R10: A line in service blocks itself and every higher-numbered line from raising `int_out`. A lower-numbered line still raises `int_out`, so service can nest.
- R11: A command-address write of 0x20 (bit 4 clear, bit 5 set) clears the lowest-numbered in-service bit.
- R12: In automatic mode, an acknowledge sets no in-service bit, so later requests at any priority raise `int_out` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: pending bits (address 0) or mask (address 1) |
| irq_in | input | 8 | Request lines, line 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge from the processor |
| vec_out | output | 8 | Vector of the last acknowledged line |
| vec_valid | output | 1 | One-cycle strobe marking a new vector |
| casc_lines | output | 8 | Lines that lead to secondary controllers |

## Verification
The assertions assume that an acknowledge never falls in the same cycle as a command-address write. They also assume that a line never rises in the same cycle in which it is acknowledged. Without these conditions, the in-service and pending updates could legally override each other. The bench keeps to both conditions: it drives each bus write, each acknowledge and each request edge on a separate falling clock edge, and it never overlaps them. Each table entry starts with a fresh command sequence, so no state carries over from one entry to the next.

// File: rtl/pic_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes an eight-line controller on a byte-wide bus.
package pic_pkg;
    localparam int IRQ_N  = 8;
    localparam int ID_W   = $clog2(IRQ_N);
    localparam int BYTE_W = 8;

    // command-word bit positions (the decode depends on them)
    localparam int START_BIT  = 4;
    localparam int EOI_BIT    = 5;
    localparam int NOCASC_BIT = 1;
    localparam int WANTMD_BIT = 0;
    localparam int AUTO_BIT   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_READY
    } seq_st_t;
endpackage

// File: rtl/pic_cfg.sv
// Command sequencer and configuration store.
// Decodes command and data writes and steps through the setup words.
// Assumes at most one write per cycle.
module pic_cfg
    import pic_pkg::*;
#(
    parameter int LINES = IRQ_N,
    parameter int DW    = BYTE_W,
    localparam int IW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [LINES-1:0] mask_q,
    output logic [DW-1:0] base_q,
    output logic [LINES-1:0] casc_q,
    output logic          auto_q,
    output logic          ready,
    output logic          start_p,
    output logic          eoi_p
);
    seq_st_t st_q;
    logic    nocasc_q, wantmd_q;
    logic    cmd_wr, dat_wr;

    // split the write strobe by address
    always_comb begin
        cmd_wr  = wr && !addr;
        dat_wr  = wr && addr;
        start_p = cmd_wr && wdata[START_BIT];
        eoi_p   = cmd_wr && !wdata[START_BIT] && wdata[EOI_BIT] && ready;
        ready   = (st_q == ST_READY);
    end

    // sequence state and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            nocasc_q <= 1'b0;
            wantmd_q <= 1'b0;
            mask_q   <= '0;
            base_q   <= '0;
            casc_q   <= '0;
            auto_q   <= 1'b0;
        end else if (start_p) begin
            st_q     <= ST_BASE;
            nocasc_q <= wdata[NOCASC_BIT];
            wantmd_q <= wdata[WANTMD_BIT];
            mask_q   <= '0;
            casc_q   <= '0;
            auto_q   <= 1'b0;
        end else if (dat_wr) begin
            case (st_q)
                ST_BASE: begin
                    base_q <= {wdata[DW-1:IW], {IW{1'b0}}};
                    if (!nocasc_q)     st_q <= ST_CASC;
                    else if (wantmd_q) st_q <= ST_MODE;
                    else               st_q <= ST_READY;
                end
                ST_CASC: begin
                    casc_q <= wdata[LINES-1:0];
                    st_q   <= wantmd_q ? ST_MODE : ST_READY;
                end
                ST_MODE: begin
                    auto_q <= wdata[AUTO_BIT];
                    st_q   <= ST_READY;
                end
                ST_READY: mask_q <= wdata[LINES-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pic_req.sv
// Request capture: one edge detector and pending bit per line.
// A new edge wins over an acknowledge clear in the same cycle.
// A sequence start clears everything.
module pic_req #(
    parameter int LINES = pic_pkg::IRQ_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic             clr_all,
    input  logic [LINES-1:0] ack_clr,
    output logic [LINES-1:0] pend_q
);
    logic [LINES-1:0] prev_q;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // remember last level and update the pending bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[i] <= 1'b0;
                pend_q[i] <= 1'b0;
            end else begin
                prev_q[i] <= irq_in[i];
                if (clr_all)                      pend_q[i] <= 1'b0;
                else if (irq_in[i] && !prev_q[i]) pend_q[i] <= 1'b1;
                else if (ack_clr[i])              pend_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_svc.sv
// Priority resolution, in-service tracking and vector output.
// Line 0 has the highest priority.
// Assumes the pending and mask inputs come from registers.
module pic_svc
    import pic_pkg::*;
#(
    parameter int LINES = IRQ_N,
    parameter int DW    = BYTE_W,
    localparam int IW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] mask,
    input  logic             ready,
    input  logic             ack,
    input  logic             eoi,
    input  logic             auto_mode,
    input  logic             clr_all,
    input  logic [DW-1:0]    base,
    output logic             int_out,
    output logic [LINES-1:0] ack_clr,
    output logic [LINES-1:0] isr_q,
    output logic [DW-1:0]    vec_q,
    output logic             vec_v_q
);
    logic [LINES-1:0] cand, isr_nxt;
    logic [IW-1:0]    cand_id, isr_id;
    logic             cand_any, isr_any, take;

    // find the lowest-numbered unmasked pending line
    always_comb begin
        cand     = pend & ~mask;
        cand_id  = '0;
        cand_any = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                cand_id  = IW'(i);
                cand_any = 1'b1;
            end
        end
    end

    // find the lowest-numbered in-service line
    always_comb begin
        isr_id  = '0;
        isr_any = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (isr_q[i]) begin
                isr_id  = IW'(i);
                isr_any = 1'b1;
            end
        end
    end

    // raise the request and form the acknowledge strobe
    always_comb begin
        int_out = ready && cand_any && (!isr_any || (cand_id < isr_id));
        take    = ack && int_out;
        ack_clr = take ? (LINES'(1) << cand_id) : '0;
    end

    // next in-service value: the end-of-service clear applies before the new set
    always_comb begin
        isr_nxt = isr_q;
        if (eoi && isr_any)      isr_nxt[isr_id]  = 1'b0;
        if (take && !auto_mode)  isr_nxt[cand_id] = 1'b1;
    end

    // in-service register and vector output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q   <= '0;
            vec_q   <= '0;
            vec_v_q <= 1'b0;
        end else begin
            isr_q   <= clr_all ? '0 : isr_nxt;
            vec_v_q <= take;
            if (take) vec_q <= base | DW'(cand_id);
        end
    end
endmodule

// File: rtl/pic_ctrl.sv
// Top of the eight-line interrupt controller.
// Joins the sequencer, the request capture and the service logic.
// Read data is combinational from registers.
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int LINES = IRQ_N,
    parameter int DW    = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] irq_in,
    output logic             int_out,
    input  logic             int_ack,
    output logic [DW-1:0]    vec_out,
    output logic             vec_valid,
    output logic [LINES-1:0] casc_lines
);
    logic [LINES-1:0] mask_w, pend_w, isr_w, ack_clr_w;
    logic [DW-1:0]    base_w;
    logic             auto_w, ready_w, start_w, eoi_w;

    pic_cfg #(.LINES(LINES), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mask_q(mask_w), .base_q(base_w), .casc_q(casc_lines), .auto_q(auto_w),
        .ready(ready_w), .start_p(start_w), .eoi_p(eoi_w)
    );

    pic_req #(.LINES(LINES)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(start_w),
        .ack_clr(ack_clr_w), .pend_q(pend_w)
    );

    pic_svc #(.LINES(LINES), .DW(DW)) u_svc (
        .clk(clk), .rst_n(rst_n), .pend(pend_w), .mask(mask_w), .ready(ready_w),
        .ack(int_ack), .eoi(eoi_w), .auto_mode(auto_w), .clr_all(start_w),
        .base(base_w), .int_out(int_out), .ack_clr(ack_clr_w), .isr_q(isr_w),
        .vec_q(vec_out), .vec_v_q(vec_valid)
    );

    // read mux: pending bits or mask
    always_comb bus_rdata = bus_addr ? DW'(mask_w) : DW'(pend_w);
endmodule

// File: rtl/pic_ctrl_chk.sv
// Property checker for pic_ctrl, attached with bind.
module pic_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       int_out,
    input logic       int_ack,
    input logic       vec_valid,
    input logic [7:0] vec_out,
    input logic [7:0] mask,
    input logic [7:0] pend,
    input logic [7:0] isr,
    input logic [7:0] base,
    input logic       auto_mode,
    input logic       ready
);
    // R8
    int_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ready);
    // R8
    int_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((pend & ~mask) != 8'h00));
    // R9
    ack_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out) |=> vec_valid);
    // R9
    vec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack && int_out));
    // R12
    isr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !auto_mode) |-> isr[vec_out[2:0]]);
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(mask));
    // R3
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[7:3] == base[7:3]));
endmodule

bind pic_ctrl pic_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .int_out(int_out), .int_ack(int_ack),
    .vec_valid(vec_valid), .vec_out(vec_out), .mask(mask_w), .pend(pend_w),
    .isr(isr_w), .base(base_w), .auto_mode(auto_w), .ready(ready_w)
);

// File: tb/sim_pic_ctrl.sv
module sim_pic_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    logic       int_ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [7:0] casc_lines;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pic_ctrl u0 (.*);

    // {mask, request pattern, expected vector (FF = none)}
    localparam logic [23:0] TAB [6] = '{
        {8'h00, 8'h81, 8'h20},
        {8'h01, 8'h81, 8'h27},
        {8'h00, 8'h0C, 8'h22},
        {8'hF0, 8'h30, 8'hFF},
        {8'h00, 8'h40, 8'h26},
        {8'h3F, 8'hFF, 8'h26}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic std_init;
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    endtask

    task automatic ack_pulse;
        @(negedge clk) int_ack = 1'b1;
        @(negedge clk) int_ack = 1'b0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int_out == 0, "R1 int", int_out, 0);
        chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
        rd(0, d); chk(d == 0, "R1 pending", d, 0);
        rd(1, d); chk(d == 0, "R1 mask", d, 0);
        chk(casc_lines == 0, "R1 casc", casc_lines, 0);
        // R1/R8: no interrupt before the sequence completes
        wr(0, 8'h11); wr(1, 8'h20);
        @(negedge clk) irq_in = 8'h01;
        @(negedge clk);
        chk(int_out == 0, "R8 not ready", int_out, 0);
        irq_in = 0;

        // table walk
        foreach (TAB[k]) begin
            std_init();
            wr(1, TAB[k][23:16]);
            @(negedge clk) irq_in = TAB[k][15:8];
            @(negedge clk);
            if (TAB[k][7:0] == 8'hFF) begin
                chk(int_out == 0, "R8 masked", int_out, 0);
            end else begin
                chk(int_out == 1, "R8 int", int_out, 1);
                ack_pulse();
                chk(vec_valid == 1, "R9 valid", vec_valid, 1);
                chk(vec_out == TAB[k][7:0], "R3 vector", vec_out, TAB[k][7:0]);
            end
            irq_in = 0;
        end

        // R4 cascade word stored
        std_init();
        chk(casc_lines == 8'h04, "R4 casc", casc_lines, 8'h04);
        // R9 acknowledge without request ignored
        ack_pulse();
        chk(vec_valid == 0, "R9 idle ack", vec_valid, 0);

        // R10 nesting, R11 end of service, R7 level hold
        @(negedge clk) irq_in = 8'h08;
        @(negedge clk);
        ack_pulse();
        chk(vec_out == 8'h23, "R9 IR3 vector", vec_out, 8'h23);
        rd(0, d); chk(d == 0, "R9 pending cleared", d, 0);
        @(negedge clk) irq_in = 8'h28;
        @(negedge clk);
        chk(int_out == 0, "R10 lower blocked", int_out, 0);
        @(negedge clk) irq_in = 8'h2A;
        @(negedge clk);
        chk(int_out == 1, "R10 higher nests", int_out, 1);
        ack_pulse();
        chk(vec_out == 8'h21, "R10 IR1 vector", vec_out, 8'h21);
        wr(0, 8'h20);
        @(negedge clk);
        chk(int_out == 0, "R11 IR3 still in service", int_out, 0);
        wr(0, 8'h20);
        @(negedge clk);
        chk(int_out == 1, "R11 IR5 released", int_out, 1);
        ack_pulse();
        chk(vec_out == 8'h25, "R11 IR5 vector", vec_out, 8'h25);
        wr(0, 8'h20);
        @(negedge clk);
        rd(0, d); chk(d == 0, "R7 held level no repend", d, 0);
        chk(int_out == 0, "R7 int", int_out, 0);
        irq_in = 0;

        // R2/R4/R5 single mode with mode word, automatic end of service
        wr(0, 8'h13); wr(1, 8'h4F); wr(1, 8'h03);
        chk(casc_lines == 0, "R4 casc skipped", casc_lines, 0);
        wr(1, 8'h00);
        rd(1, d); chk(d == 0, "R6 mask", d, 0);
        @(negedge clk) irq_in = 8'h10;
        @(negedge clk);
        ack_pulse();
        chk(vec_out == 8'h4C, "R3 base low bits dropped", vec_out, 8'h4C);
        @(negedge clk) irq_in = 8'h50;
        @(negedge clk);
        chk(int_out == 1, "R12 no in-service", int_out, 1);
        irq_in = 0;

        // R5 no mode word: cascade word then mask directly
        wr(0, 8'h10); wr(1, 8'h60); wr(1, 8'h81); wr(1, 8'hAA);
        chk(casc_lines == 8'h81, "R5 casc", casc_lines, 8'h81);
        rd(1, d); chk(d == 8'hAA, "R5 mask after casc", d, 8'hAA);
        // R6 masked pending visible, R2 start clears it
        @(negedge clk) irq_in = 8'h02;
        @(negedge clk);
        rd(0, d); chk(d == 8'h02, "R6 pending read", d, 8'h02);
        chk(int_out == 0, "R6 masked line", int_out, 0);
        wr(0, 8'h11);
        rd(0, d); chk(d == 0, "R2 pending cleared", d, 0);
        rd(1, d); chk(d == 0, "R2 mask cleared", d, 0);
        chk(casc_lines == 0, "R2 casc cleared", casc_lines, 0);
        irq_in = 0;

        done = 1;
        report();
    end
endmodule